// File: doc/BRIEF.md
# External Clock Failure Switchover Controller

This controller watches the status of the external high-frequency clock source. While the external source is the selected system clock, a drop of its ready status counts as a source failure. The controller then moves the system back to the internal RC oscillator without waiting for software. It turns the RC oscillator on, forces the effective clock select to the internal source and holds the system-clock-ready indication low for a short settling window. It also raises a sticky failure flag, which can request an interrupt.

The switched-over state is kept until software writes the clock configuration again. The ready status arrives asynchronously, so it is resynchronised before edge detection. All logic runs on a free-running reference clock. The oscillators and the glitch-free clock multiplexer sit outside this block. They consume its enable, select and ready outputs.

Top module: `clkfail_switch`

## Requirements
- R1: A failure is detected only when the effective select is 1 (external) and the synchronised ready status falls from 1 to 0. A fall of `ext_rdy_i` set up before rising edge k takes effect at edge k+2 (two synchroniser flops plus one edge register). A fall while the select is 0 causes no reaction.
- R2: `rc_on_o` is high from the switchover edge onward, whatever `rc_en_i` holds. After the next software configuration write it again equals `rc_en_i`. Before any failure it equals `rc_en_i`.
- R3: On a failure, `sel_ext_o` becomes 0 (0 = internal RC, 1 = external). A software configuration write in the same cycle as a failure is overridden by the failure.
- R4: `clk_ready_o` is low for exactly RDY_DLY cycles (default 4) after any edge that changes the clock source. Such a change is either a failure or a software write that changes the select value. Otherwise `clk_ready_o` is 1.
- R5: A failure sets `fail_flag_o` to 1, and it stays 1 until software clears it.
- R6: `irq_o` is 1 exactly when `fail_flag_o` is 1 and `irq_en_i` is 1.
- R7: Without a software configuration write, the select stays at 0 after a failure, even if the external ready status returns and toggles again.
- R8: Writing 0 through the flag write port clears `fail_flag_o` at the next edge. Writing 1 through it has no effect. A failure in the same cycle as a clear leaves the flag at 1.
- R9: After reset, `sel_ext_o` is 0, `clk_ready_o` is 1, `fail_flag_o` is 0, `irq_o` is 0 and `rc_on_o` equals `rc_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_rdy_i | input | 1 | External source ready status (asynchronous) |
| rc_en_i | input | 1 | Software RC oscillator enable |
| irq_en_i | input | 1 | Failure interrupt enable |
| cfg_we_i | input | 1 | Software clock configuration write strobe |
| cfg_sel_i | input | 1 | Select value written (1 = external) |
| flag_we_i | input | 1 | Failure flag write strobe |
| flag_wdata_i | input | 1 | Failure flag write data (0 clears) |
| rc_on_o | output | 1 | RC oscillator enable to the analog block |
| sel_ext_o | output | 1 | Effective clock select (1 = external) |
| clk_ready_o | output | 1 | System clock ready |
| fail_flag_o | output | 1 | Sticky external clock failure flag |
| irq_o | output | 1 | Failure interrupt request |

## Verification
Each internal state bit drives a port directly or through one gate. A wrong select, force or flag register therefore shows on `sel_ext_o`, `rc_on_o`, `fail_flag_o` or `irq_o` in the first cycle after the bad edge. A wrong synchroniser depth or edge register shifts the switchover by a cycle relative to the fall of `ext_rdy_i`. A miscounted settling counter lengthens or shortens the low window of `clk_ready_o`. The bench compares every output against a reference model every cycle, so any of these errors is reported in the cycle it first appears.

// File: rtl/clkfail_pkg.sv
package clkfail_pkg;

    typedef struct packed {
        logic sel;       // effective select, 1 = external
        logic forced;    // RC forced on by a failure
        logic flag;      // sticky failure flag
        logic rdy_prev;  // previous synchronised ready
    } sw_state_t;

    localparam sw_state_t SW_STATE_RST = '{sel: 1'b0, forced: 1'b0, flag: 1'b0, rdy_prev: 1'b0};

endpackage

// File: rtl/clkfail_sync.sv
module clkfail_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] ff_d;
    logic [STAGES-1:0] ff_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb ff_d = d_i;
        end else begin : g_chain
            always_comb ff_d = {ff_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= ff_d;
    end

    assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/clkfail_rdy_delay.sv
module clkfail_rdy_delay #(
    parameter int DLY = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic ready_o
);
    localparam int CNT_W = $clog2(DLY + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DLY);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)            cnt_d = CNT_LOAD;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign ready_o = (cnt_q == '0);
endmodule

// File: rtl/clkfail_switch.sv
module clkfail_switch
    import clkfail_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RDY_DLY     = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ext_rdy_i,
    input  logic rc_en_i,
    input  logic irq_en_i,
    input  logic cfg_we_i,
    input  logic cfg_sel_i,
    input  logic flag_we_i,
    input  logic flag_wdata_i,
    output logic rc_on_o,
    output logic sel_ext_o,
    output logic clk_ready_o,
    output logic fail_flag_o,
    output logic irq_o
);
    sw_state_t st_d;
    sw_state_t st_q;
    logic      rdy_sync;
    logic      fall_w;
    logic      fail_w;
    logic      src_chg_w;

    clkfail_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (ext_rdy_i),
        .q_o    (rdy_sync)
    );

    always_comb begin
        st_d      = st_q;
        fall_w    = st_q.rdy_prev & ~rdy_sync;
        fail_w    = st_q.sel & fall_w;
        src_chg_w = 1'b0;

        st_d.rdy_prev = rdy_sync;

        if (fail_w) begin
            st_d.sel    = 1'b0;
            st_d.forced = 1'b1;
            src_chg_w   = 1'b1;
        end else if (cfg_we_i) begin
            st_d.sel    = cfg_sel_i;
            st_d.forced = 1'b0;
            src_chg_w   = (cfg_sel_i != st_q.sel);
        end

        if (fail_w)                        st_d.flag = 1'b1;
        else if (flag_we_i && !flag_wdata_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= SW_STATE_RST;
        else         st_q <= st_d;
    end

    clkfail_rdy_delay #(.DLY(RDY_DLY)) u_dly (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (src_chg_w),
        .ready_o (clk_ready_o)
    );

    assign rc_on_o     = rc_en_i | st_q.forced;
    assign sel_ext_o   = st_q.sel;
    assign fail_flag_o = st_q.flag;
    assign irq_o       = st_q.flag & irq_en_i;
endmodule

// File: rtl/clkfail_switch_chk.sv
module clkfail_switch_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic fail_i,
    input logic src_chg_i,
    input logic rc_en_i,
    input logic irq_en_i,
    input logic cfg_we_i,
    input logic flag_we_i,
    input logic flag_wdata_i,
    input logic rc_on_o,
    input logic sel_ext_o,
    input logic clk_ready_o,
    input logic fail_flag_o,
    input logic irq_o
);
    p_fail_needs_ext_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fail_i |-> sel_ext_o);

    p_rc_forced_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fail_i |=> rc_on_o);

    p_rc_off_needs_sw_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rc_on_o |-> !rc_en_i);

    p_sel_forced_int_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fail_i |=> !sel_ext_o);

    p_ready_drops_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        src_chg_i |=> !clk_ready_o);

    p_flag_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fail_i |=> fail_flag_o);

    p_irq_needs_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (fail_flag_o && irq_en_i));

    p_sel_rise_by_sw_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sel_ext_o) |-> $past(cfg_we_i));

    p_flag_clear_by_sw_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(fail_flag_o) |-> $past(flag_we_i && !flag_wdata_i));
endmodule

bind clkfail_switch clkfail_switch_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fail_i       (fail_w),
    .src_chg_i    (src_chg_w),
    .rc_en_i      (rc_en_i),
    .irq_en_i     (irq_en_i),
    .cfg_we_i     (cfg_we_i),
    .flag_we_i    (flag_we_i),
    .flag_wdata_i (flag_wdata_i),
    .rc_on_o      (rc_on_o),
    .sel_ext_o    (sel_ext_o),
    .clk_ready_o  (clk_ready_o),
    .fail_flag_o  (fail_flag_o),
    .irq_o        (irq_o)
);

// File: tb/clkfail_switch_bench.sv
module clkfail_switch_bench;
    localparam int DLY = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_rdy = 1'b0, rc_en = 1'b0, irq_en = 1'b0;
    logic cfg_we = 1'b0, cfg_sel = 1'b0, flag_we = 1'b0, flag_wdata = 1'b0;
    logic rc_on, sel_ext, clk_ready, fail_flag, irq;

    int checks = 0;
    int fails  = 0;

    // reference model state
    logic m_s1 = 1'b0, m_s2 = 1'b0, m_prev = 1'b0;
    logic m_sel = 1'b0, m_forced = 1'b0, m_flag = 1'b0;
    int   m_cnt = 0;

    always #2 clk = ~clk;

    clkfail_switch #(.SYNC_STAGES(2), .RDY_DLY(DLY)) u_clkfail_switch (
        .clk_i(clk), .rst_ni(rst_n), .ext_rdy_i(ext_rdy), .rc_en_i(rc_en),
        .irq_en_i(irq_en), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
        .flag_we_i(flag_we), .flag_wdata_i(flag_wdata),
        .rc_on_o(rc_on), .sel_ext_o(sel_ext), .clk_ready_o(clk_ready),
        .fail_flag_o(fail_flag), .irq_o(irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_rc_on();  return rc_en | m_forced;   endfunction
    function automatic logic exp_irq();    return m_flag & irq_en;    endfunction
    function automatic logic exp_ready();  return (m_cnt == 0);       endfunction

    task automatic model_edge();
        logic fail;
        fail = m_sel & m_prev & ~m_s2;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_rdy;
        if (fail) begin
            m_cnt = DLY; m_sel = 1'b0; m_forced = 1'b1;
        end else begin
            if (cfg_we && (cfg_sel != m_sel)) m_cnt = DLY;
            else if (m_cnt != 0) m_cnt = m_cnt - 1;
            if (cfg_we) begin m_sel = cfg_sel; m_forced = 1'b0; end
        end
        if (fail) m_flag = 1'b1;
        else if (flag_we && !flag_wdata) m_flag = 1'b0;
    endtask

    task automatic compare_all();
        chk("R3 sel_ext_o", sel_ext, m_sel);
        chk("R2 rc_on_o", rc_on, exp_rc_on());
        chk("R4 clk_ready_o", clk_ready, exp_ready());
        chk("R5 fail_flag_o", fail_flag, m_flag);
        chk("R6 irq_o", irq, exp_irq());
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_wr();
        cfg_we = 1'b0; flag_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rc_en = 1'b0; irq_en = 1'b1; ext_rdy = 1'b1;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 reset sel", sel_ext, 1'b0);
        chk("R9 reset ready", clk_ready, 1'b1);
        chk("R9 reset flag", fail_flag, 1'b0);
        chk("R9 reset irq", irq, 1'b0);
        chk("R9 reset rc_on", rc_on, rc_en);
        rst_n = 1'b1;
        repeat (4) step();

        // R1 with select 0: a fall is ignored
        ext_rdy = 1'b0;
        repeat (6) step();
        chk("R1 no reaction with select 0", fail_flag, 1'b0);
        ext_rdy = 1'b1;
        repeat (4) step();

        // select external, wait for settle (R4)
        cfg_we = 1'b1; cfg_sel = 1'b1;
        step(); idle_wr();
        chk("R4 ready low after sw change", clk_ready, 1'b0);
        repeat (DLY) step();
        chk("R4 ready back after window", clk_ready, 1'b1);

        // R1 latency and R2 forced RC with rc_en 0
        ext_rdy = 1'b0;
        step(); step();
        chk("R1 not yet switched after two edges", sel_ext, 1'b1);
        step();
        chk("R1 switched at third edge", sel_ext, 1'b0);
        chk("R2 rc forced on", rc_on, 1'b1);
        for (int i = 1; i < DLY; i++) step();
        chk("R4 ready still low at last window cycle", clk_ready, 1'b0);
        step();
        chk("R4 ready high after window", clk_ready, 1'b1);

        // R7: ready returns and toggles, no sw write
        ext_rdy = 1'b1; repeat (4) step();
        ext_rdy = 1'b0; repeat (4) step();
        chk("R7 select held internal", sel_ext, 1'b0);
        chk("R7 rc still forced", rc_on, 1'b1);

        // R8: write 1 no effect, write 0 clears
        flag_we = 1'b1; flag_wdata = 1'b1; step(); idle_wr();
        chk("R8 write one no effect", fail_flag, 1'b1);
        flag_we = 1'b1; flag_wdata = 1'b0; step(); idle_wr();
        chk("R8 write zero clears", fail_flag, 1'b0);
        chk("R6 irq drops with flag", irq, 1'b0);

        // R3/R8 priority: failure with sw write and clear in same cycle
        ext_rdy = 1'b1;
        cfg_we = 1'b1; cfg_sel = 1'b1; step(); idle_wr();
        repeat (DLY + 2) step();
        ext_rdy = 1'b0;
        step(); step();
        cfg_we = 1'b1; cfg_sel = 1'b1; flag_we = 1'b1; flag_wdata = 1'b0;
        step(); idle_wr();
        chk("R3 failure beats sw write", sel_ext, 1'b0);
        chk("R8 failure beats clear", fail_flag, 1'b1);
        // R2: sw write releases the force
        cfg_we = 1'b1; cfg_sel = 1'b0; step(); idle_wr();
        chk("R2 rc follows software after write", rc_on, rc_en);

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(7) == 0) ext_rdy = ~ext_rdy;
            if ($urandom_range(15) == 0) rc_en = ~rc_en;
            if ($urandom_range(15) == 0) irq_en = ~irq_en;
            cfg_we = ($urandom_range(19) == 0);
            cfg_sel = ($urandom_range(3) != 0);
            flag_we = ($urandom_range(24) == 0);
            flag_wdata = $urandom_range(1);
            step();
        end
        idle_wr();
        step();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule